// File: doc/BRIEF.md
# Chip-Select Window Segment Decoder

This block splits one memory-mapped flash address range into separate windows, one per chip select. Each chip select owns a segment register that records where its window begins and ends, both counted in 8 MB granules. Software programs these registers through a simple write and read port. A bus access presents an address on the lookup port. Within the same cycle, the block returns a one-hot chip select and the byte offset of the access inside the selected window. If no window covers the address, it raises a decode-error flag instead.

The start field of chip select 0 sets the base of the whole mapped range. A write that would push a window's end beyond that base plus the configured total range is dropped, so reading the register back shows that the write did not take. A window whose start is not below its end is closed and matches nothing. When open windows overlap, the lowest-numbered chip select takes the access.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset every segment register reads 0, so every window is closed and any valid lookup reports a decode error.
- R2: The segment register of chip select i sits at byte offset 0x30 + 4*i. It reads back with the window end in bits [31:24], the window start in bits [23:16], and zeros in bits [15:0], whatever was written to those low bits. Any other offset reads 0, and writes to it change nothing.
- R3: A valid lookup whose address bits [31:23] (the granule index) satisfy start <= index < end for chip select i drives bit i of lk_cs. lk_cs never has more than one bit set.
- R4: A window whose start is greater than or equal to its end matches no address.
- R5: When several open windows cover the address, the lowest-numbered chip select is the one reported.
- R6: On a match, lk_offset equals the lookup address minus (start << 23) of the selected window. With no match it is 0.
- R7: A valid lookup that matches no open window sets lk_err and leaves lk_cs at 0. When lk_valid is low, both lk_cs and lk_err are 0.
- R8: A write whose end field exceeds base + RANGE_UNITS is not stored, and the register keeps its previous value. Here base is the start field of chip select 0, or the newly written start when the write targets chip select 0 itself. RANGE_UNITS defaults to 32, which is 256 MB.
- R9: An accepted write takes effect at the clock edge that samples it. Lookups and reads in the following cycle see the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset, used for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| lk_valid | input | 1 | Lookup request valid |
| lk_addr | input | 32 | Lookup byte address |
| lk_cs | output | 3 | One-hot chip select of the matching window |
| lk_offset | output | 32 | Byte offset within the selected window |
| lk_err | output | 1 | Decode error: valid lookup with no matching window |

## Verification
The hardest case to reach is a write rejected against a base set by a different register. A window that was legal when written only becomes out of range after chip select 0 moves the base, and a later write to that window is then dropped. The stimulus first builds a contiguous three-window map. It then moves the base of chip select 0 and attempts a write whose end is legal for the old base but not for the new one. Overlap priority and closed windows are reached by rewriting chip select 1 over an already populated map, and each result is compared by a scoreboard against a requirement-level model.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
    localparam int FIELD_W = 8;

    typedef struct packed {
        logic [FIELD_W-1:0] fend;
        logic [FIELD_W-1:0] fstart;
    } seg_t;
endpackage

// File: rtl/seg_regs.sv
module seg_regs
    import segdec_pkg::*;
#(
    parameter int NUM_CS      = 3,
    parameter int RANGE_UNITS = 32,
    parameter int REG_BASE    = 8'h30
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [7:0]               addr_i,
    input  logic [31:0]              wdata_i,
    output logic [31:0]              rdata_o,
    output seg_t [NUM_CS-1:0]        segs_o
);
    typedef struct packed {
        seg_t [NUM_CS-1:0] seg;
    } state_t;

    state_t state_d, state_q;

    logic [7:0]        rel_off;
    logic [NUM_CS-1:0] sel;
    seg_t              new_seg;
    logic [8:0]        base_ext;
    logic [8:0]        limit;
    logic              fits;

    assign rel_off = addr_i - 8'(REG_BASE);
    assign new_seg = seg_t'(wdata_i[31:16]);

    always_comb begin
        for (int k = 0; k < NUM_CS; k++) begin
            sel[k] = (addr_i >= 8'(REG_BASE)) && (rel_off[1:0] == 2'b00)
                     && (rel_off[7:2] == 6'(k));
        end
    end

    assign base_ext = sel[0] ? {1'b0, new_seg.fstart} : {1'b0, state_q.seg[0].fstart};
    assign limit    = base_ext + 9'(RANGE_UNITS);
    assign fits     = ({1'b0, new_seg.fend} <= limit);

    always_comb begin
        state_d = state_q;
        rdata_o = 32'h0;
        for (int k = 0; k < NUM_CS; k++) begin
            if (sel[k]) begin
                rdata_o = {state_q.seg[k], 16'h0000};
                if (wr_en_i && fits) begin
                    state_d.seg[k] = new_seg;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign segs_o = state_q.seg;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_chk
        p_reject_keep_r8 : assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && sel[g] && !fits) |=> $stable(segs_o[g]));
        p_accept_store_r9 : assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && sel[g] && fits) |=> (segs_o[g] == $past(wdata_i[31:16])));
        p_other_keep_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            (!(wr_en_i && sel[g])) |=> $stable(segs_o[g]));
    end
endmodule

// File: rtl/seg_match.sv
module seg_match
    import segdec_pkg::*;
#(
    parameter int NUM_CS     = 3,
    parameter int ADDR_W     = 32,
    parameter int UNIT_SHIFT = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  seg_t [NUM_CS-1:0]     segs_i,
    input  logic                  valid_i,
    input  logic [ADDR_W-1:0]     addr_i,
    output logic [NUM_CS-1:0]     cs_o,
    output logic [ADDR_W-1:0]     offset_o,
    output logic                  err_o
);
    localparam int UW = ADDR_W - UNIT_SHIFT;
    localparam int CW = (UW > FIELD_W) ? UW : FIELD_W;

    logic [CW-1:0]     unit;
    logic [NUM_CS-1:0] hit;

    assign unit = CW'(addr_i[ADDR_W-1:UNIT_SHIFT]);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_win
        logic [CW-1:0] s_ext, e_ext;
        assign s_ext  = CW'(segs_i[g].fstart);
        assign e_ext  = CW'(segs_i[g].fend);
        assign hit[g] = valid_i && (s_ext < e_ext) && (unit >= s_ext) && (unit < e_ext);

        p_inside_r3 : assert property (@(posedge clk) disable iff (!rst_n)
            cs_o[g] |-> ((unit >= s_ext) && (unit < e_ext)));
        p_closed_r4 : assert property (@(posedge clk) disable iff (!rst_n)
            cs_o[g] |-> (segs_i[g].fstart < segs_i[g].fend));
    end

    always_comb begin
        logic found;
        found    = 1'b0;
        cs_o     = '0;
        offset_o = '0;
        for (int k = 0; k < NUM_CS; k++) begin
            if (hit[k] && !found) begin
                found    = 1'b1;
                cs_o[k]  = 1'b1;
                offset_o = addr_i - (ADDR_W'(segs_i[k].fstart) << UNIT_SHIFT);
            end
        end
        err_o = valid_i && !found;
    end

    p_onehot_r3 : assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs_o));
    p_err_nocs_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (cs_o == '0));
    p_offset_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (cs_o == '0) |-> (offset_o == '0));
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
    import segdec_pkg::*;
#(
    parameter int NUM_CS      = 3,
    parameter int ADDR_W      = 32,
    parameter int UNIT_SHIFT  = 23,
    parameter int RANGE_UNITS = 32,
    parameter int REG_BASE    = 8'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic [NUM_CS-1:0] lk_cs,
    output logic [ADDR_W-1:0] lk_offset,
    output logic              lk_err
);
    seg_t [NUM_CS-1:0] segs;

    seg_regs #(
        .NUM_CS      (NUM_CS),
        .RANGE_UNITS (RANGE_UNITS),
        .REG_BASE    (REG_BASE)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (reg_wr_en),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .segs_o  (segs)
    );

    seg_match #(
        .NUM_CS     (NUM_CS),
        .ADDR_W     (ADDR_W),
        .UNIT_SHIFT (UNIT_SHIFT)
    ) match_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .segs_i   (segs),
        .valid_i  (lk_valid),
        .addr_i   (lk_addr),
        .cs_o     (lk_cs),
        .offset_o (lk_offset),
        .err_o    (lk_err)
    );

    p_idle_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> ((lk_cs == '0) && !lk_err));
endmodule

// File: tb/cs_window_decoder_tb_top.sv
module cs_window_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = 32'h0;
    logic [2:0]  lk_cs;
    logic [31:0] lk_offset;
    logic        lk_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        bit          is_rd;
        logic [31:0] rd;
        logic [2:0]  cs;
        logic [31:0] off;
        logic        err;
        string       tag;
    } item_t;

    item_t q[$];
    logic [31:0] mseg [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_window_decoder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lk_valid  (lk_valid),
        .lk_addr   (lk_addr),
        .lk_cs     (lk_cs),
        .lk_offset (lk_offset),
        .lk_err    (lk_err)
    );

    // Monitor: pops one expectation per cycle and compares
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            if (it.is_rd) begin
                if (reg_rdata !== it.rd) begin
                    bad++;
                    $display("FAIL %s: rdata actual=%h expected=%h", it.tag, reg_rdata, it.rd);
                end
            end else if (lk_cs !== it.cs || lk_offset !== it.off || lk_err !== it.err) begin
                bad++;
                $display("FAIL %s: actual cs=%b off=%h err=%b expected cs=%b off=%h err=%b",
                         it.tag, lk_cs, lk_offset, lk_err, it.cs, it.off, it.err);
            end
        end
    end

    function automatic int reg_idx(input logic [7:0] a);
        if (a >= 8'h30 && a[1:0] == 2'b00 && ((a - 8'h30) >> 2) < 3) return int'((a - 8'h30) >> 2);
        return -1;
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        int idx;
        int base;
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
        idx = reg_idx(a);
        if (idx >= 0) begin
            base = (idx == 0) ? int'(d[23:16]) : int'(mseg[0][23:16]);
            if (int'(d[31:24]) <= base + 32) mseg[idx] = {d[31:16], 16'h0};
        end
    endtask

    task automatic do_read(input logic [7:0] a, input string tag);
        item_t it;
        int idx;
        @(posedge clk); #1;
        reg_addr = a;
        idx = reg_idx(a);
        it.is_rd = 1; it.rd = (idx >= 0) ? mseg[idx] : 32'h0;
        it.cs = 0; it.off = 0; it.err = 0; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic do_lookup(input bit v, input logic [31:0] a, input string tag);
        item_t it;
        int unit;
        @(posedge clk); #1;
        lk_valid = v; lk_addr = a;
        it.is_rd = 0; it.rd = 0; it.cs = 0; it.off = 0; it.err = 0; it.tag = tag;
        if (v) begin
            unit = int'(a[31:23]);
            for (int k = 0; k < 3; k++) begin
                int s, e;
                s = int'(mseg[k][23:16]);
                e = int'(mseg[k][31:24]);
                if (it.cs == 0 && s < e && unit >= s && unit < e) begin
                    it.cs[k] = 1'b1;
                    it.off = a - (32'(s) << 23);
                end
            end
            it.err = (it.cs == 0);
        end
        q.push_back(it);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 3; k++) mseg[k] = 32'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        do_read(8'h30, "R1 reset seg0");
        do_read(8'h38, "R1 reset seg2");
        do_lookup(1, 32'h1000_0000, "R1 reset lookup err");

        // R9 build contiguous map, base 0x20 (0x1000_0000)
        do_write(8'h30, 32'h2220_0000);
        do_write(8'h34, 32'h2822_0000);
        do_write(8'h38, 32'h4028_0000);
        do_read(8'h30, "R9 seg0 stored");
        do_read(8'h34, "R2 seg1 at 0x34");
        do_read(8'h38, "R8 seg2 end at limit stored");

        // R3 R6 lookups
        do_lookup(1, 32'h1000_0000, "R3 cs0 first byte");
        do_lookup(1, 32'h10FF_FFFF, "R6 cs0 last byte");
        do_lookup(1, 32'h1100_0000, "R3 cs1 start");
        do_lookup(1, 32'h1400_0010, "R6 cs2 offset");
        do_lookup(1, 32'h1FFF_FFFF, "R6 cs2 last byte");
        do_lookup(1, 32'h2000_0000, "R7 past end err");
        do_lookup(1, 32'h0FFF_FFFF, "R7 below base err");
        do_lookup(0, 32'h1000_0000, "R7 not valid idle");

        // R8 rejection
        do_write(8'h38, 32'h4128_0000);
        do_read(8'h38, "R8 seg2 overflow rejected");
        do_lookup(1, 32'h1FFF_FFFF, "R8 map unchanged");

        // R2 unmapped and low bits
        do_write(8'h3C, 32'hFFFF_FFFF);
        do_read(8'h3C, "R2 unmapped reads 0");
        do_read(8'h31, "R2 unaligned reads 0");
        do_lookup(1, 32'h1FFF_FFFF, "R2 unmapped write no effect");
        do_write(8'h34, 32'h2822_ABCD);
        do_read(8'h34, "R2 low bits read zero");

        // R4 closed window
        do_write(8'h34, 32'h2222_0000);
        do_lookup(1, 32'h1100_0000, "R4 closed equal");
        do_write(8'h34, 32'h2124_0000);
        do_lookup(1, 32'h1180_0000, "R4 closed start>end");

        // R5 overlap
        do_write(8'h34, 32'h2420_0000);
        do_lookup(1, 32'h1000_0000, "R5 overlap low cs wins");
        do_lookup(1, 32'h1100_0000, "R5 cs1 beyond cs0");
        do_lookup(1, 32'h1200_0000, "R3 end exclusive err");

        // R8 base moved by chip 0
        do_write(8'h30, 32'h3010_0000);
        do_read(8'h30, "R8 seg0 new base stored");
        do_write(8'h38, 32'h3128_0000);
        do_read(8'h38, "R8 seg2 rejected by new base");
        do_write(8'h30, 32'h4110_0000);
        do_read(8'h30, "R8 seg0 own limit rejected");
        do_lookup(1, 32'h0800_0000, "R3 cs0 new base");

        @(posedge clk); #1;
        lk_valid = 0;
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule